// File: doc/BRIEF.md
# Wide Big-Number ALU with Flag Groups

This block is the arithmetic and logic stage of a big-number accelerator. Each cycle in which `opValid` is high, it takes two operand words (256 bits by default), an opcode, a byte pre-shift for the second operand, an immediate, a funnel shift count, a flag-group index and a flag index. It registers a result word, a write strobe and updated flags on the next rising clock edge. The register file, decode and memory stay outside the block. The operands and controls arrive on ports, and the result leaves on ports.

Two independent flag groups are held inside the block. Each group has four bits. Bit 0 is C (carry or borrow), bit 1 is L (result bit 0), bit 2 is M (result most significant bit) and bit 3 is Z (result is zero). Group g sits in `flagBank[4g+3:4g]`. The block also holds a modulus register, loaded through its own write port. The modular add and modular subtract fold their truncated result back below this modulus with a single conditional subtraction.

Top module: `bnum_alu`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `resWe` is 0, `resData` is 0, every bit of `flagBank` is 0 and the modulus is 0.
- R2: Opcodes 0 (add), 1 (add with carry) and 4 (add immediate) produce (A + B' + cin) mod 2^W. For opcodes 0 and 1, B' is the pre-shifted second operand. For opcode 4, B' is the zero-extended `immVal`. cin is 0 for opcodes 0 and 4, and cin is the selected group's C for opcode 1. C becomes the carry-out.
- R3: Opcodes 2 (subtract), 3 (subtract with borrow) and 5 (subtract immediate) produce (A − B' − bin) mod 2^W, with B' chosen as in R2. bin is the selected group's C for opcode 3 and 0 otherwise. C becomes 1 exactly when A < B' + bin.
- R4: The byte pre-shift moves `opB` by 8·`shiftBytes` bits with zero fill: left when `shiftRight` is 0 and right when it is 1. It applies only to opcodes 0, 1, 2, 3, 8, 9, 12 and 13. Every other opcode sees `opB` unshifted.
- R5: Opcodes 0–5, 12 and 13 write {Z, M, L, C} into the group given by `flagGroup`. L, M and Z are taken from the arithmetic result. The other group is left unchanged. All remaining opcodes leave both groups unchanged.
- R6: Opcodes 12 (compare) and 13 (compare with borrow) set flags exactly like opcodes 2 and 3. They keep `resWe` at 0 and leave `resData` unchanged.
- R7: Opcode 6 (modular add) forms s = (A + B) mod 2^W. It returns s − N if s ≥ N and s otherwise, where N is the modulus.
- R8: Opcode 7 (modular subtract) forms s = (A − B) mod 2^W. It returns s − N if s ≥ N and s otherwise.
- R9: A `modWe` pulse loads `modIn` at the clock edge. A modular operation issued in that same cycle still uses the previous modulus.
- R10: Opcode 8 returns A AND B' and opcode 9 returns A OR B', where B' is the pre-shifted operand. Opcode 10 returns A XOR B with B unshifted. Opcode 11 returns NOT A.
- R11: Opcode 14 returns the low W bits of the 2W-bit value {A, B} shifted right by `shiftBits`.
- R12: Opcode 15 returns A when bit `flagSel` of the selected group is 1, and B otherwise.
- R13: Every opcode except 12 and 13 raises `resWe` for exactly one cycle, one clock after the `opValid` cycle. When `opValid` is 0, `resWe` stays 0 and `resData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation issue strobe |
| opCode | input | 4 | Operation select (see requirements) |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| immVal | input | IMM_W | Immediate for opcodes 4 and 5 |
| shiftBytes | input | log2(WIDTH/8) | Byte count of the pre-shift |
| shiftRight | input | 1 | Pre-shift direction, 1 = right |
| shiftBits | input | log2(WIDTH) | Bit count for the funnel shift |
| flagGroup | input | log2(FLAG_GROUPS) | Flag group used and updated |
| flagSel | input | 2 | Flag index for select: 0 C, 1 L, 2 M, 3 Z |
| modWe | input | 1 | Modulus load strobe |
| modIn | input | WIDTH | New modulus value |
| resWe | output | 1 | Result write strobe |
| resData | output | WIDTH | Registered result |
| flagBank | output | 4·FLAG_GROUPS | All flag groups, group g in bits 4g+3..4g |

## Verification
The cycle that needs care is the one where a modulus load and a modular add or subtract are issued together. The operation must fold against the old modulus, and the new one must take effect only from the next operation on. The bench provokes this case in two ways. It opens every modulus epoch of its sweep with a modular add that carries the modulus write. It also runs a dedicated pair in which 60 + 50 returns 110 against the old modulus 0xFFFF, and the following identical operation returns 10 against the new modulus 100. Its arithmetic model judges each result by applying the pending modulus only after computing that cycle's expected value.

// File: rtl/bnum_alu_pkg.sv
package bnum_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_ADDI = 4'd4,
    OP_SUBI = 4'd5,
    OP_ADDM = 4'd6,
    OP_SUBM = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_CMP  = 4'd12,
    OP_CMPB = 4'd13,
    OP_RSHI = 4'd14,
    OP_SEL  = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG,
    CIN_FLAGN
  } cin_e;

  typedef enum logic [2:0] {
    SRC_SUM,
    SRC_MOD,
    SRC_AND,
    SRC_OR,
    SRC_XOR,
    SRC_NOT,
    SRC_FUNNEL,
    SRC_SEL
  } src_e;

  typedef struct packed {
    logic useShift;
    logic invB;
    logic useImm;
    cin_e cinSel;
    src_e resSrc;
    logic writeRes;
    logic writeFlags;
  } ctrl_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_L = 1;
  localparam int FLAG_M = 2;
  localparam int FLAG_Z = 3;

endpackage

// File: rtl/bnum_alu_ctrl.sv
module bnum_alu_ctrl
  import bnum_alu_pkg::*;
(
  input  logic                opValid,
  input  logic [3:0]          opCode,
  output bnum_alu_pkg::ctrl_t ctrl
);

  ctrl_t dec;

  always_comb begin
    dec = '0;
    dec.cinSel = CIN_ZERO;
    dec.resSrc = SRC_SUM;
    dec.writeRes = 1'b1;
    unique case (opCode)
      OP_ADD:  begin dec.useShift = 1'b1; dec.writeFlags = 1'b1; end
      OP_ADDC: begin dec.useShift = 1'b1; dec.cinSel = CIN_FLAG; dec.writeFlags = 1'b1; end
      OP_SUB:  begin dec.useShift = 1'b1; dec.invB = 1'b1; dec.cinSel = CIN_ONE; dec.writeFlags = 1'b1; end
      OP_SUBB: begin dec.useShift = 1'b1; dec.invB = 1'b1; dec.cinSel = CIN_FLAGN; dec.writeFlags = 1'b1; end
      OP_ADDI: begin dec.useImm = 1'b1; dec.writeFlags = 1'b1; end
      OP_SUBI: begin dec.useImm = 1'b1; dec.invB = 1'b1; dec.cinSel = CIN_ONE; dec.writeFlags = 1'b1; end
      OP_ADDM: dec.resSrc = SRC_MOD;
      OP_SUBM: begin dec.invB = 1'b1; dec.cinSel = CIN_ONE; dec.resSrc = SRC_MOD; end
      OP_AND:  begin dec.useShift = 1'b1; dec.resSrc = SRC_AND; end
      OP_OR:   begin dec.useShift = 1'b1; dec.resSrc = SRC_OR; end
      OP_XOR:  dec.resSrc = SRC_XOR;
      OP_NOT:  dec.resSrc = SRC_NOT;
      OP_CMP:  begin dec.useShift = 1'b1; dec.invB = 1'b1; dec.cinSel = CIN_ONE;
                     dec.writeFlags = 1'b1; dec.writeRes = 1'b0; end
      OP_CMPB: begin dec.useShift = 1'b1; dec.invB = 1'b1; dec.cinSel = CIN_FLAGN;
                     dec.writeFlags = 1'b1; dec.writeRes = 1'b0; end
      OP_RSHI: dec.resSrc = SRC_FUNNEL;
      OP_SEL:  dec.resSrc = SRC_SEL;
      default: dec = '0;
    endcase
  end

  always_comb begin
    ctrl = dec;
    ctrl.writeRes   = dec.writeRes & opValid;
    ctrl.writeFlags = dec.writeFlags & opValid;
  end

endmodule

// File: rtl/bnum_alu_dp.sv
module bnum_alu_dp
  import bnum_alu_pkg::*;
#(
  parameter int WIDTH       = 256,
  parameter int IMM_W       = 10,
  parameter int FLAG_GROUPS = 2,
  localparam int SB_W       = $clog2(WIDTH / 8),
  localparam int SH_W       = $clog2(WIDTH),
  localparam int GRP_W      = $clog2(FLAG_GROUPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bnum_alu_pkg::ctrl_t      ctrl,
  input  logic [WIDTH-1:0]         opA,
  input  logic [WIDTH-1:0]         opB,
  input  logic [IMM_W-1:0]         immVal,
  input  logic [SB_W-1:0]          shiftBytes,
  input  logic                     shiftRight,
  input  logic [SH_W-1:0]          shiftBits,
  input  logic [GRP_W-1:0]         flagGroup,
  input  logic [1:0]               flagSel,
  input  logic                     modWe,
  input  logic [WIDTH-1:0]         modIn,
  output logic                     resWe,
  output logic [WIDTH-1:0]         resData,
  output logic [4*FLAG_GROUPS-1:0] flagBank
);

  logic [FLAG_GROUPS-1:0][3:0] flagReg;
  logic [WIDTH-1:0]            modReg;
  logic [3:0]                  curFlags;
  logic [WIDTH-1:0]            bShifted, bOperand, bAdder;
  logic                        carryIn;
  logic [WIDTH:0]              sumFull, corrFull;
  logic [WIDTH-1:0]            sum, modResult, funnelOut, result;
  logic [2*WIDTH-1:0]          catShift;
  logic [3:0]                  newFlags;

  assign curFlags = flagReg[flagGroup];

  // byte pre-shift of the second operand
  always_comb begin
    if (!ctrl.useShift)  bShifted = opB;
    else if (shiftRight) bShifted = opB >> {shiftBytes, 3'b000};
    else                 bShifted = opB << {shiftBytes, 3'b000};
  end

  assign bOperand = ctrl.useImm ? {{(WIDTH-IMM_W){1'b0}}, immVal} : bShifted;
  assign bAdder   = ctrl.invB ? ~bOperand : bOperand;

  always_comb begin
    unique case (ctrl.cinSel)
      CIN_ZERO:  carryIn = 1'b0;
      CIN_ONE:   carryIn = 1'b1;
      CIN_FLAG:  carryIn = curFlags[FLAG_C];
      default:   carryIn = ~curFlags[FLAG_C];
    endcase
  end

  assign sumFull = {1'b0, opA} + {1'b0, bAdder} + {{WIDTH{1'b0}}, carryIn};
  assign sum     = sumFull[WIDTH-1:0];

  // single conditional modulus correction
  assign corrFull  = {1'b0, sum} - {1'b0, modReg};
  assign modResult = corrFull[WIDTH] ? sum : corrFull[WIDTH-1:0];

  assign catShift  = {opA, opB} >> shiftBits;
  assign funnelOut = catShift[WIDTH-1:0];

  always_comb begin
    unique case (ctrl.resSrc)
      SRC_SUM:    result = sum;
      SRC_MOD:    result = modResult;
      SRC_AND:    result = opA & bShifted;
      SRC_OR:     result = opA | bShifted;
      SRC_XOR:    result = opA ^ opB;
      SRC_NOT:    result = ~opA;
      SRC_FUNNEL: result = funnelOut;
      default:    result = curFlags[flagSel] ? opA : opB;
    endcase
  end

  always_comb begin
    newFlags[FLAG_C] = sumFull[WIDTH] ^ ctrl.invB;
    newFlags[FLAG_L] = sum[0];
    newFlags[FLAG_M] = sum[WIDTH-1];
    newFlags[FLAG_Z] = (sum == '0);
  end

  for (genvar g = 0; g < FLAG_GROUPS; g++) begin : g_flagGroup
    always_ff @(posedge clk) begin
      if (!rstN)
        flagReg[g] <= '0;
      else if (ctrl.writeFlags && (flagGroup == GRP_W'(g)))
        flagReg[g] <= newFlags;
    end
    assign flagBank[4*g +: 4] = flagReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modReg  <= '0;
      resWe   <= 1'b0;
      resData <= '0;
    end else begin
      if (modWe) modReg <= modIn;
      resWe <= ctrl.writeRes;
      if (ctrl.writeRes) resData <= result;
    end
  end

endmodule

// File: rtl/bnum_alu.sv
module bnum_alu
  import bnum_alu_pkg::*;
#(
  parameter int WIDTH       = 256,
  parameter int IMM_W       = 10,
  parameter int FLAG_GROUPS = 2,
  localparam int SB_W       = $clog2(WIDTH / 8),
  localparam int SH_W       = $clog2(WIDTH),
  localparam int GRP_W      = $clog2(FLAG_GROUPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  logic [3:0]               opCode,
  input  logic [WIDTH-1:0]         opA,
  input  logic [WIDTH-1:0]         opB,
  input  logic [IMM_W-1:0]         immVal,
  input  logic [SB_W-1:0]          shiftBytes,
  input  logic                     shiftRight,
  input  logic [SH_W-1:0]          shiftBits,
  input  logic [GRP_W-1:0]         flagGroup,
  input  logic [1:0]               flagSel,
  input  logic                     modWe,
  input  logic [WIDTH-1:0]         modIn,
  output logic                     resWe,
  output logic [WIDTH-1:0]         resData,
  output logic [4*FLAG_GROUPS-1:0] flagBank
);

  ctrl_t ctrl;

  bnum_alu_ctrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  bnum_alu_dp #(
    .WIDTH       (WIDTH),
    .IMM_W       (IMM_W),
    .FLAG_GROUPS (FLAG_GROUPS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .immVal     (immVal),
    .shiftBytes (shiftBytes),
    .shiftRight (shiftRight),
    .shiftBits  (shiftBits),
    .flagGroup  (flagGroup),
    .flagSel    (flagSel),
    .modWe      (modWe),
    .modIn      (modIn),
    .resWe      (resWe),
    .resData    (resData),
    .flagBank   (flagBank)
  );

endmodule

// File: rtl/bnum_alu_chk.sv
module bnum_alu_chk
  import bnum_alu_pkg::*;
#(
  parameter int WIDTH       = 256,
  parameter int FLAG_GROUPS = 2,
  localparam int GRP_W      = $clog2(FLAG_GROUPS)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     opValid,
  input logic [3:0]               opCode,
  input logic [WIDTH-1:0]         opA,
  input logic [WIDTH-1:0]         opB,
  input logic [GRP_W-1:0]         flagGroup,
  input logic                     modWe,
  input logic [WIDTH-1:0]         modIn,
  input logic                     resWe,
  input logic [WIDTH-1:0]         resData,
  input logic [4*FLAG_GROUPS-1:0] flagBank
);

  logic [WIDTH-1:0] shadowMod;
  logic             noFlagOp;

  always_ff @(posedge clk) begin
    if (!rstN)      shadowMod <= '0;
    else if (modWe) shadowMod <= modIn;
  end

  assign noFlagOp = (opCode == OP_ADDM) || (opCode == OP_SUBM) || (opCode == OP_AND) ||
                    (opCode == OP_OR) || (opCode == OP_XOR) || (opCode == OP_NOT) ||
                    (opCode == OP_RSHI) || (opCode == OP_SEL);

  p_idle_no_write_r13: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resWe && $stable(resData)));

  p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_CMP || opCode == OP_CMPB)) |=> (!resWe && $stable(resData)));

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && noFlagOp) |=> $stable(flagBank));

  p_other_group_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && flagGroup == '0) |=> $stable(flagBank[4*FLAG_GROUPS-1:4]));

  p_add_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ADD && flagGroup == '0) |=>
      (flagBank[3] == (resData == '0) && flagBank[2] == resData[WIDTH-1] &&
       flagBank[1] == resData[0]));

  p_mod_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ADDM && shadowMod != '0 && opA < shadowMod && opB < shadowMod)
      |=> (resData < $past(shadowMod)));

endmodule

bind bnum_alu bnum_alu_chk #(
  .WIDTH       (WIDTH),
  .FLAG_GROUPS (FLAG_GROUPS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .opA       (opA),
  .opB       (opB),
  .flagGroup (flagGroup),
  .modWe     (modWe),
  .modIn     (modIn),
  .resWe     (resWe),
  .resData   (resData),
  .flagBank  (flagBank)
);

// File: tb/bnum_alu_tb_top.sv
`timescale 1ns/1ps
module bnum_alu_tb_top;
  import bnum_alu_pkg::*;

  localparam int W   = 16;
  localparam int IW  = 8;
  localparam int SBW = $clog2(W / 8);
  localparam int SHW = $clog2(W);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [3:0]    opCode = '0;
  logic [W-1:0]  opA = '0, opB = '0, modIn = '0;
  logic [IW-1:0] immVal = '0;
  logic [SBW-1:0] shiftBytes = '0;
  logic          shiftRight = 1'b0;
  logic [SHW-1:0] shiftBits = '0;
  logic          flagGroup = 1'b0;
  logic [1:0]    flagSel = '0;
  logic          modWe = 1'b0;
  logic          resWe;
  logic [W-1:0]  resData;
  logic [7:0]    flagBank;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [3:0]   mFlags [2];
  logic [W-1:0] mMod;
  logic [W-1:0] mRes;

  always #4 clk = ~clk;

  bnum_alu #(.WIDTH(W), .IMM_W(IW), .FLAG_GROUPS(2)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA), .opB(opB),
    .immVal(immVal), .shiftBytes(shiftBytes), .shiftRight(shiftRight), .shiftBits(shiftBits),
    .flagGroup(flagGroup), .flagSel(flagSel), .modWe(modWe), .modIn(modIn),
    .resWe(resWe), .resData(resData), .flagBank(flagBank)
  );

  function automatic string reqOf(input int op);
    case (op)
      0, 1, 4:   return "R2";
      2, 3, 5:   return "R3";
      6:         return "R7";
      7:         return "R8";
      8, 9, 10, 11: return "R10";
      12, 13:    return "R6";
      14:        return "R11";
      default:   return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [W+8:0] act, input logic [W+8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [IW-1:0] imm, input int sb, input bit sr, input int sh,
                       input bit grp, input int fsel, input bit mwe, input logic [W-1:0] mval,
                       input string tag);
    logic [W-1:0] bs, bo, r;
    logic [3:0]   fl;
    longint       d;
    bit           wr, wf, cflag;
    @(negedge clk);
    opValid = 1'b1; opCode = 4'(op); opA = a; opB = b; immVal = imm;
    shiftBytes = SBW'(sb); shiftRight = sr; shiftBits = SHW'(sh);
    flagGroup = grp; flagSel = 2'(fsel); modWe = mwe; modIn = mval;
    // expected value (R4: pre-shift only for 0,1,2,3,8,9,12,13)
    if (op inside {0, 1, 2, 3, 8, 9, 12, 13}) bs = sr ? (b >> (8 * sb)) : (b << (8 * sb));
    else bs = b;
    bo = (op inside {4, 5}) ? W'(imm) : bs;
    cflag = mFlags[grp][0];
    wr = !(op inside {12, 13});
    wf = (op inside {0, 1, 2, 3, 4, 5, 12, 13});
    fl = 4'b0;
    r = '0;
    case (op)
      0, 1, 4: begin
        d = longint'(a) + longint'(bo) + ((op == 1) ? longint'(cflag) : 0);
        r = W'(d); fl[0] = (d >= (64'sd1 << W));
      end
      2, 3, 5, 12, 13: begin
        d = longint'(a) - longint'(bo) - ((op == 3 || op == 13) ? longint'(cflag) : 0);
        r = W'(d); fl[0] = (d < 0);
      end
      6, 7: begin
        r = (op == 6) ? W'(a + b) : W'(a - b);
        if (r >= mMod) r = r - mMod;
      end
      8:  r = a & bs;
      9:  r = a | bs;
      10: r = a ^ b;
      11: r = ~a;
      14: r = W'({a, b} >> sh);
      default: r = mFlags[grp][fsel] ? a : b;
    endcase
    fl[1] = r[0]; fl[2] = r[W-1]; fl[3] = (r == '0);
    if (wf) mFlags[grp] = fl;
    if (wr) mRes = r;
    if (mwe) mMod = mval;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; modWe = 1'b0;
    check(tag == "" ? reqOf(op) : tag, {1'b0, resWe, resData, flagBank},
          {1'b0, wr, mRes, mFlags[1], mFlags[0]});
  endtask

  initial begin
    logic [W-1:0] vals [8];
    logic [W-1:0] mods [4];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF, 16'hA5C3, 16'h1234};
    mods = '{16'h8001, 16'hFFFF, 16'h0000, 16'h1234};
    mFlags[0] = '0; mFlags[1] = '0; mMod = '0; mRes = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {1'b0, resWe, resData, flagBank}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {1'b0, resWe, resData, flagBank}, '0);

    // R9: modulus load in the same cycle as a modular add uses the old modulus
    runOp(6, 16'd10, 16'd20, 8'd0, 0, 0, 0, 0, 0, 1, 16'hFFFF, "R9");
    runOp(6, 16'd60, 16'd50, 8'd0, 0, 0, 0, 0, 0, 1, 16'd100, "R9");
    check("R9", {1'b0, resWe, resData, 8'h00}, {1'b0, 1'b1, 16'd110, 8'h00});
    runOp(6, 16'd60, 16'd50, 8'd0, 0, 0, 0, 0, 0, 0, 16'd0, "R9");
    check("R9", {1'b0, resWe, resData, 8'h00}, {1'b0, 1'b1, 16'd10, 8'h00});

    // R13: idle cycle holds the result and raises no write
    opA = 16'hDEAD; opB = 16'hBEEF; opCode = 4'(OP_XOR);
    @(posedge clk);
    @(negedge clk);
    check("R13", {1'b0, resWe, resData, flagBank}, {1'b0, 1'b0, mRes, mFlags[1], mFlags[0]});

    // R4: explicit pre-shift cases
    runOp(0, 16'h0000, 16'h00AB, 8'd0, 1, 0, 0, 0, 0, 0, 16'd0, "R4");
    runOp(8, 16'hFFFF, 16'hAB00, 8'd0, 1, 1, 0, 1, 0, 0, 16'd0, "R4");
    runOp(10, 16'h0000, 16'hAB00, 8'd0, 1, 1, 0, 1, 0, 0, 16'd0, "R4");

    // R5 / R2 / R3 sweep; R9 again at the start of each modulus epoch
    for (int m = 0; m < 4; m++) begin
      runOp(6, 16'hF0F0, 16'h0F0F, 8'd0, 0, 0, 0, 0, 0, 1, mods[m], "R9");
      for (int op = 0; op < 16; op++)
        for (int ia = 0; ia < 8; ia++)
          for (int ib = 0; ib < 8; ib++)
            for (int v = 0; v < 8; v++)
              runOp(op, vals[ia], vals[ib], vals[ib][7:0] ^ 8'(v * 37), v & 1, v[1], (ia * 2 + ib + v) % 16,
                    v[2], (ia + ib + op) % 4, 0, 16'd0, (v[2] ? "R5" : ""));
    end

    opValid = 1'b0;
    @(negedge clk);
    check("R13", {1'b0, resWe, 16'h0, 8'h0}, '0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule